// File: doc/BRIEF.md
# Maskable Interrupt Acceptance Sequencer

This block decides, at each instruction boundary, whether a pending maskable interrupt request is taken. When it is, the block runs a fixed entry sequence. It saves the return address as two bytes on a downward-growing byte stack through a memory write port. It then presents the processor's new program counter, stack pointer and refresh counter, drops both interrupt enable bits and pulses a wake signal that releases a halted core.

The core keeps ownership of its architectural registers. It offers their current values on the inputs and copies the results from the outputs in the cycle where `done` is high. The PC, SP and refresh values are captured when the request is taken, so the core may change those inputs freely while the sequence runs.

The memory write port is a valid/ready stream. Once `wr_valid` is high, `wr_addr` and `wr_data` hold steady until a cycle with `wr_ready` high completes the transfer. The sink may stall for any number of cycles. No other pin has a handshake.

Top module: `irq_accept_seq`

## Requirements
- R1: A request is taken on a clock edge only when the sequencer is idle and all of the following hold: `at_boundary` high, `irq_req` high, `ie1_in` high, and `int_mode` equal to 0 or 1. Otherwise no write is issued and `busy` stays low.
- R2: A request is taken at most once per assertion of `irq_req`. The request cannot be taken again until `irq_req` has been seen low on a clock edge.
- R3: The first stack write carries PC[15:8] to address SP−1. The second carries PC[7:0] to address SP−2. Both addresses are modulo 2^16.
- R4: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values. The sequence advances only on a cycle with both high.
- R5: When `done` is high, `pc_out` equals 0x0038.
- R6: When `done` is high, `sp_out` equals the captured SP minus 2, modulo 2^16.
- R7: When `done` is high, `rfr_out[6:0]` equals the captured refresh value's low 7 bits plus one, wrapping within 7 bits. `rfr_out[7]` equals the captured bit 7.
- R8: From the cycle after a request is taken through the `done` cycle, `busy` is high and `ie1_out` and `ie2_out` are both low. While idle, `ie1_out` and `ie2_out` equal `ie1_in` and `ie2_in`.
- R9: `done` and `wake` rise together for exactly one cycle. That cycle follows the edge that completes the second write. `busy` is low in the next cycle.
- R10: PC, SP and refresh are captured on the edge where the request is taken. Later changes to `pc_in`, `sp_in` and `rfr_in` do not affect the writes or the results.
- R11: After reset, `busy`, `done`, `wake` and `wr_valid` are low, and `pc_out`, `sp_out` and `rfr_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| at_boundary | input | 1 | High when the core is between instructions |
| irq_req | input | 1 | Maskable interrupt request level |
| ie1_in | input | 1 | Primary interrupt enable bit from the core |
| ie2_in | input | 1 | Shadow interrupt enable bit from the core |
| int_mode | input | 2 | Current interrupt mode; only 0 and 1 are serviced |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| rfr_in | input | 8 | Current refresh counter |
| wr_valid | output | 1 | Stack write request valid |
| wr_ready | input | 1 | Memory accepts the stack write |
| wr_addr | output | 16 | Stack write address |
| wr_data | output | 8 | Stack write byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse; results valid |
| wake | output | 1 | One-cycle halt-release pulse |
| pc_out | output | 16 | New program counter |
| sp_out | output | 16 | New stack pointer |
| rfr_out | output | 8 | New refresh counter |
| ie1_out | output | 1 | Primary enable seen by the core |
| ie2_out | output | 1 | Shadow enable seen by the core |

## Verification
The bench exercises acceptance with random PC, SP and refresh values under random memory stall patterns. Changing the operand inputs mid-sequence separates a design that captures its operands from one that reads them live. Directed cases each gate one acceptance condition at a time: enable low, mode 2, no boundary, and a held request after completion. This shows that each condition blocks acceptance on its own and that the held request is not taken twice. An SP of 0x0001 and refresh values 0x7F and 0xFF probe address wrap, 7-bit wrap and preservation of bit 7. These are cases that a plain 8-bit increment or an SP arithmetic slip would get wrong.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2,
    ST_DONE = 2'd3
  } seq_st_t;

  localparam logic [15:0] SVC_VECTOR = 16'h0038;
endpackage

// File: rtl/irq_accept_gate.sv
module irq_accept_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       at_boundary,
  input  logic       irq_req,
  input  logic       ie1,
  input  logic [1:0] int_mode,
  input  logic       idle,
  output logic       take
);
  logic armed;

  assign take = idle && at_boundary && irq_req && ie1 && armed && !int_mode[1];

  always_ff @(posedge clk) begin
    if (!rst_n)        armed <= 1'b1;
    else if (take)     armed <= 1'b0;
    else if (!irq_req) armed <= 1'b1;
  end

  // R2
  single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  // R2
  held_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq_req) |=> (irq_req |-> !take));
endmodule

// File: rtl/irq_push_fsm.sv
module irq_push_fsm
  import irq_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [2*DW-1:0] pc_in,
  input  logic [AW-1:0]   sp_in,
  input  logic            wr_ready,
  output logic            wr_valid,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            idle,
  output logic            done,
  output logic            last_ack,
  output logic [AW-1:0]   sp_final
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  seq_st_t          st;
  logic [2*DW-1:0]  pc_cap;
  logic [AW-1:0]    sp_cap;

  assign idle     = (st == ST_IDLE);
  assign done     = (st == ST_DONE);
  assign wr_valid = (st == ST_HI) || (st == ST_LO);
  assign wr_addr  = (st == ST_HI) ? (sp_cap - ONE) : (sp_cap - TWO);
  assign wr_data  = (st == ST_HI) ? pc_cap[2*DW-1:DW] : pc_cap[DW-1:0];
  assign last_ack = (st == ST_LO) && wr_ready;
  assign sp_final = sp_cap - TWO;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      pc_cap <= '0;
      sp_cap <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (take) begin
          st     <= ST_HI;
          pc_cap <= pc_in;
          sp_cap <= sp_in;
        end
        ST_HI:   if (wr_ready) st <= ST_LO;
        ST_LO:   if (wr_ready) st <= ST_DONE;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HI && wr_ready) |=> (wr_valid && wr_addr == $past(wr_addr) - ONE));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
  import irq_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int RW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            at_boundary,
  input  logic            irq_req,
  input  logic            ie1_in,
  input  logic            ie2_in,
  input  logic [1:0]      int_mode,
  input  logic [2*DW-1:0] pc_in,
  input  logic [AW-1:0]   sp_in,
  input  logic [RW-1:0]   rfr_in,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            busy,
  output logic            done,
  output logic            wake,
  output logic [2*DW-1:0] pc_out,
  output logic [AW-1:0]   sp_out,
  output logic [RW-1:0]   rfr_out,
  output logic            ie1_out,
  output logic            ie2_out
);
  localparam int RL = RW - 1;

  logic          take, idle, last_ack;
  logic [AW-1:0] sp_final;
  logic [RW-1:0] rfr_cap;

  irq_accept_gate u_gate (
    .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .irq_req(irq_req),
    .ie1(ie1_in), .int_mode(int_mode), .idle(idle), .take(take)
  );

  irq_push_fsm #(.AW(AW), .DW(DW)) u_push (
    .clk(clk), .rst_n(rst_n), .take(take), .pc_in(pc_in), .sp_in(sp_in),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .idle(idle), .done(done), .last_ack(last_ack),
    .sp_final(sp_final)
  );

  assign busy    = !idle;
  assign wake    = done;
  assign ie1_out = idle && ie1_in;
  assign ie2_out = idle && ie2_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rfr_cap <= '0;
      pc_out  <= '0;
      sp_out  <= '0;
      rfr_out <= '0;
    end else begin
      if (take) rfr_cap <= rfr_in;
      if (last_ack) begin
        pc_out  <= (2*DW)'(SVC_VECTOR);
        sp_out  <= sp_final;
        rfr_out <= {rfr_cap[RL], rfr_cap[RL-1:0] + RL'(1)};
      end
    end
  end

  // R5
  vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_out == (2*DW)'(SVC_VECTOR)));

  // R7
  rfr_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rfr_out[RL] == rfr_cap[RL]));

  // R8
  ie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!ie1_out && !ie2_out && busy));
endmodule

// File: tb/irq_accept_seq_bench.sv
module irq_accept_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        at_boundary = 1'b0, irq_req = 1'b0, ie1_in = 1'b0, ie2_in = 1'b0;
  logic [1:0]  int_mode = 2'd0;
  logic [15:0] pc_in = '0, sp_in = '0;
  logic [7:0]  rfr_in = '0;
  logic        wr_ready = 1'b0;
  logic        wr_valid, busy, done, wake, ie1_out, ie2_out;
  logic [15:0] wr_addr, pc_out, sp_out;
  logic [7:0]  wr_data, rfr_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_accept_seq u_irq_accept_seq (
    .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .irq_req(irq_req),
    .ie1_in(ie1_in), .ie2_in(ie2_in), .int_mode(int_mode), .pc_in(pc_in),
    .sp_in(sp_in), .rfr_in(rfr_in), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done),
    .wake(wake), .pc_out(pc_out), .sp_out(sp_out), .rfr_out(rfr_out),
    .ie1_out(ie1_out), .ie2_out(ie2_out)
  );

  function automatic logic [7:0] exp_rfr(input logic [7:0] r);
    return {r[7], r[6:0] + 7'd1};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Holds a request for a few boundary cycles while one condition blocks acceptance.
  task automatic expect_ignored(input string req);
    int seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (busy || wr_valid) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic run_seq(input logic [15:0] pc, input logic [15:0] sp,
                         input logic [7:0] rf, input logic [1:0] md,
                         input int stall_pct);
    logic [15:0] ea [2];
    logic [7:0]  ed [2];
    int idx = 0;
    bit got_done = 0;
    ea[0] = sp - 16'd1; ed[0] = pc[15:8];
    ea[1] = sp - 16'd2; ed[1] = pc[7:0];
    @(negedge clk);
    irq_req = 1'b0; at_boundary = 1'b0;
    @(negedge clk);
    pc_in = pc; sp_in = sp; rfr_in = rf; int_mode = md;
    ie1_in = 1'b1; ie2_in = 1'b1; irq_req = 1'b1; at_boundary = 1'b1;
    @(negedge clk);
    at_boundary = 1'b0;
    // R8: enables dropped and busy once taken
    chk(busy && !ie1_out && !ie2_out, "R8", {busy, ie1_out, ie2_out}, 3'b100);
    // R10: operand inputs scrambled after capture
    pc_in = 16'($urandom); sp_in = 16'($urandom); rfr_in = 8'($urandom);
    for (int c = 0; c < 60 && !got_done; c++) begin
      if (done) begin
        got_done = 1;
        chk(idx == 2, "R3", idx, 2);
        chk(pc_out == 16'h0038, "R5", pc_out, 16'h0038);
        chk(sp_out == sp - 16'd2, "R6 R10", sp_out, sp - 16'd2);
        chk(rfr_out == exp_rfr(rf), "R7 R10", rfr_out, exp_rfr(rf));
        chk(wake && busy && !ie1_out && !ie2_out, "R8 R9", {wake, busy, ie1_out, ie2_out}, 4'b1100);
        wr_ready = 1'b0;
      end else begin
        if (wr_valid) begin
          // R4: while stalled the same write stays presented
          chk(idx < 2 && wr_addr == ea[idx] && wr_data == ed[idx], "R3 R4",
              {wr_addr, wr_data}, {ea[idx & 1], ed[idx & 1]});
          wr_ready = (($urandom % 100) >= stall_pct);
          if (wr_ready) idx++;
        end else begin
          chk(1'b0, "R4", wr_valid, 1);
        end
        @(negedge clk);
      end
    end
    chk(got_done, "R9", got_done, 1);
    @(negedge clk);
    chk(!done && !wake && !busy, "R9", {done, wake, busy}, 3'b000);
    chk(ie1_out == ie1_in, "R8", ie1_out, ie1_in);
    // R2: request still high, enables high, boundary high: not taken again
    at_boundary = 1'b1;
    expect_ignored("R2");
    at_boundary = 1'b0;
    irq_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11
    chk(!busy && !done && !wake && !wr_valid, "R11", {busy, done, wake, wr_valid}, 0);
    chk(pc_out == 0 && sp_out == 0 && rfr_out == 0, "R11", {pc_out, sp_out, rfr_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: each blocking condition on its own
    pc_in = 16'h1234; sp_in = 16'h8000; ie2_in = 1'b1;
    ie1_in = 1'b0; int_mode = 2'd1; irq_req = 1'b1; at_boundary = 1'b1;
    expect_ignored("R1 ie1 low");
    chk(ie2_out == 1'b1 && ie1_out == 1'b0, "R8 idle passthrough", {ie1_out, ie2_out}, 2'b01);
    ie1_in = 1'b1; int_mode = 2'd2;
    expect_ignored("R1 mode2");
    int_mode = 2'd0; at_boundary = 1'b0;
    expect_ignored("R1 no boundary");
    irq_req = 1'b0; at_boundary = 1'b1;
    expect_ignored("R1 no request");
    at_boundary = 1'b0;

    // directed corners
    run_seq(16'hABCD, 16'h0001, 8'h7F, 2'd0, 0);
    run_seq(16'h00FF, 16'h0000, 8'hFF, 2'd1, 50);
    run_seq(16'hFF00, 16'h4000, 8'h80, 2'd1, 90);

    // random
    for (int t = 0; t < 20; t++)
      run_seq(16'($urandom), 16'($urandom), 8'($urandom), 2'($urandom % 2), int'($urandom % 80));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule